// File: doc/BRIEF.md
# Erased-Sector ECC Parity Filter

This block sits beside a Reed-Solomon codec that protects each 512-byte flash sector with 9 parity bytes. It deals with blank sectors, whose bytes all read as 0xFF. On the program path, the parity stream from the encoder passes through the block on its way to the spare area. When the 9 bytes equal the fixed parity of an all-0xFF sector, the block sends nine 0xFF bytes in their place. A sector written as blank therefore stays in the erased state on the medium, and a later partial-page program can still fill it.

On the read path the block sees every byte of a sector before the decoder does. Once the last byte has arrived it gives a one-cycle verdict. It either marks the sector as erased, so the decoder is skipped and zero corrections are reported, or it issues a start pulse to the decoder. A running level shows as soon as a sector can no longer be blank, so software or a sequencer can abandon the blank check early.

Top module: `erased_sector_filter`

## Requirements
- R1: After a synchronous reset the block is in this state: `wr_in_ready`=1, `wr_out_valid`=0, `rd_done`=0, `rd_erased`=0, `rd_decode_go`=0, `rd_dirty`=0.
- R2: The write path accepts exactly 9 input bytes, one per cycle in which `wr_in_valid` and `wr_in_ready` are both high. It then holds `wr_in_ready` low and offers exactly 9 output beats. After the last output handshake it accepts input again.
- R3: The 9 input bytes may equal, in order, CD 9D 90 58 F4 8B FF B7 6F. In that case every one of the 9 output bytes is 0xFF.
- R4: For any other 9-byte input, the output bytes equal the input bytes, unchanged and in the same order.
- R5: While `wr_out_valid` is high and `wr_out_ready` is low, `wr_out_valid` and `wr_out_data` hold their values into the next cycle.
- R6: A read sector is 521 bytes, taken on cycles with `rd_valid` high. The 9 stored parity bytes come first, then the 512 data bytes. Idle cycles between bytes are allowed. `rd_done` is high for exactly the one cycle after the cycle that carries byte 521.
- R7: `rd_erased` is high together with `rd_done` exactly when all 521 bytes of the sector were 0xFF. At all other times it is low.
- R8: `rd_decode_go` is high together with `rd_done` exactly when the sector was not erased. At all other times it is low.
- R9: `rd_dirty` goes high in the cycle after the first non-0xFF byte of a sector. It stays high until the end of that sector, and it is low in the cycle of `rd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_in_valid | input | 1 | Encoder parity byte valid |
| wr_in_ready | output | 1 | Block accepts a parity byte |
| wr_in_data | input | 8 | Encoder parity byte |
| wr_out_valid | output | 1 | Filtered parity byte valid |
| wr_out_ready | input | 1 | Spare-area writer accepts a byte |
| wr_out_data | output | 8 | Filtered parity byte |
| rd_valid | input | 1 | Read byte valid |
| rd_data | input | 8 | Read byte (parity first, then data) |
| rd_done | output | 1 | One-cycle end-of-sector pulse |
| rd_erased | output | 1 | Sector found blank, with rd_done |
| rd_decode_go | output | 1 | Start decoder, with rd_done |
| rd_dirty | output | 1 | Sector already known not blank |

## Verification
A wrong byte index on the write path shows at the ports within one sector. It appears either as a byte that reaches the output in the wrong position or as a golden pattern that is not replaced. A stuck match flag shows the same way: it either swaps a near-miss pattern or passes the blank pattern through. On the read path, a miscounted position moves `rd_done` off the cycle after byte 521, and this is visible at the first sector end. A dirty flag that is not cleared shows at the next all-0xFF sector, which would then start the decoder. The directed near-miss patterns therefore place the single differing byte at the first, middle and last positions.

// File: rtl/esf_pkg.sv
package esf_pkg;
  localparam int PAR_BYTES  = 9;
  localparam int DATA_BYTES = 512;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
  // Encoder output for a sector that holds only 0xFF, in stream order.
  localparam logic [7:0] BLANK_PARITY [PAR_BYTES] =
    '{8'hCD, 8'h9D, 8'h90, 8'h58, 8'hF4, 8'h8B, 8'hFF, 8'hB7, 8'h6F};
endpackage

// File: rtl/esf_wr_filter.sv
module esf_wr_filter
  import esf_pkg::*;
#(
  parameter int NBYTES = PAR_BYTES
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int IW = $clog2(NBYTES);
  localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

  typedef enum logic {S_FILL, S_DRAIN} st_t;

  st_t          st_q;
  logic [IW-1:0] idx_q;
  logic          match_q;
  logic          swap_q;
  logic [7:0]    hold_q [NBYTES];
  logic          hit;

  assign hit = (in_data == BLANK_PARITY[idx_q]);

  // Byte store without reset so it can map onto distributed or block memory.
  always_ff @(posedge clk) begin
    if (st_q == S_FILL && in_valid)
      hold_q[idx_q] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_FILL;
      idx_q   <= '0;
      match_q <= 1'b1;
      swap_q  <= 1'b0;
    end else begin
      case (st_q)
        S_FILL: if (in_valid) begin
          if (idx_q == LAST) begin
            st_q   <= S_DRAIN;
            idx_q  <= '0;
            swap_q <= match_q && hit;
          end else begin
            idx_q   <= idx_q + 1'b1;
            match_q <= match_q && hit;
          end
        end
        S_DRAIN: if (out_ready) begin
          if (idx_q == LAST) begin
            st_q    <= S_FILL;
            idx_q   <= '0;
            match_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= S_FILL;
      endcase
    end
  end

  assign in_ready  = (st_q == S_FILL);
  assign out_valid = (st_q == S_DRAIN);
  assign out_data  = swap_q ? ERASED_BYTE : hold_q[idx_q];
endmodule

// File: rtl/esf_rd_scan.sv
module esf_rd_scan
  import esf_pkg::*;
#(
  parameter int NPAR  = PAR_BYTES,
  parameter int NDATA = DATA_BYTES
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       valid,
  input  logic [7:0] data,
  output logic       done,
  output logic       erased,
  output logic       decode_go,
  output logic       dirty
);
  localparam int TOTAL = NPAR + NDATA;
  localparam int CW    = $clog2(TOTAL);
  localparam logic [CW-1:0] LASTPOS = CW'(TOTAL - 1);

  logic [CW-1:0] pos_q;
  logic          bad;

  assign bad = dirty || (data != ERASED_BYTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      dirty     <= 1'b0;
      done      <= 1'b0;
      erased    <= 1'b0;
      decode_go <= 1'b0;
    end else begin
      done      <= 1'b0;
      erased    <= 1'b0;
      decode_go <= 1'b0;
      if (valid) begin
        if (pos_q == LASTPOS) begin
          pos_q     <= '0;
          dirty     <= 1'b0;
          done      <= 1'b1;
          erased    <= !bad;
          decode_go <= bad;
        end else begin
          pos_q <= pos_q + 1'b1;
          dirty <= bad;
        end
      end
    end
  end
endmodule

// File: rtl/erased_sector_filter.sv
module erased_sector_filter
  import esf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_in_valid,
  output logic       wr_in_ready,
  input  logic [7:0] wr_in_data,
  output logic       wr_out_valid,
  input  logic       wr_out_ready,
  output logic [7:0] wr_out_data,
  input  logic       rd_valid,
  input  logic [7:0] rd_data,
  output logic       rd_done,
  output logic       rd_erased,
  output logic       rd_decode_go,
  output logic       rd_dirty
);
  esf_wr_filter #(.NBYTES(PAR_BYTES)) wr_i (
    .clk(clk), .rst(rst),
    .in_valid(wr_in_valid), .in_ready(wr_in_ready), .in_data(wr_in_data),
    .out_valid(wr_out_valid), .out_ready(wr_out_ready), .out_data(wr_out_data)
  );

  esf_rd_scan #(.NPAR(PAR_BYTES), .NDATA(DATA_BYTES)) rd_i (
    .clk(clk), .rst(rst),
    .valid(rd_valid), .data(rd_data),
    .done(rd_done), .erased(rd_erased), .decode_go(rd_decode_go),
    .dirty(rd_dirty)
  );
endmodule

// File: rtl/esf_checker.sv
module esf_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr_in_valid,
  input logic       wr_in_ready,
  input logic       wr_out_valid,
  input logic       wr_out_ready,
  input logic [7:0] wr_out_data,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       rd_done,
  input logic       rd_erased,
  input logic       rd_decode_go,
  input logic       rd_dirty
);
  // R2
  io_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_in_valid && wr_in_ready) |-> !wr_out_valid);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_out_valid && !wr_out_ready) |=> (wr_out_valid && $stable(wr_out_data)));

  // R6
  done_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_done) |-> $past(rd_valid));

  // R7
  erased_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    rd_erased |-> rd_done);

  // R8
  go_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> $onehot({rd_erased, rd_decode_go}));

  // R9
  dirty_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_dirty) |-> $past(rd_valid && rd_data != 8'hFF));

  // R9
  dirty_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> !rd_dirty);
endmodule

bind erased_sector_filter esf_checker chk_i (.*);

// File: tb/erased_sector_filter_tb.sv
`timescale 1ns/1ps
module erased_sector_filter_tb_top;
  localparam int NP = 9;
  localparam int NT = 521;
  localparam logic [7:0] GOLD [NP] =
    '{8'hCD, 8'h9D, 8'h90, 8'h58, 8'hF4, 8'h8B, 8'hFF, 8'hB7, 8'h6F};

  logic clk = 1'b0;
  logic rst;
  logic wr_in_valid, wr_in_ready, wr_out_valid, wr_out_ready;
  logic [7:0] wr_in_data, wr_out_data, rd_data;
  logic rd_valid, rd_done, rd_erased, rd_decode_go, rd_dirty;

  int total = 0;
  int bad = 0;
  logic [7:0] pv [NP];
  logic [7:0] sec [NT];

  always #2.5 clk = ~clk;

  erased_sector_filter dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic is_gold();
    for (int i = 0; i < NP; i++) if (pv[i] != GOLD[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_wr(input int stall_pct);
    logic sw;
    int n;
    sw = is_gold();
    for (int i = 0; i < NP; i++) begin
      check("R2 in_ready", wr_in_ready, 1);
      wr_in_valid = 1'b1;
      wr_in_data  = pv[i];
      @(negedge clk);
    end
    wr_in_valid = 1'b0;
    n = 0;
    while (n < NP) begin
      wr_out_ready = (($urandom % 100) >= stall_pct);
      check("R2 drain", {wr_out_valid, wr_in_ready}, 2'b10);
      if (wr_out_ready) begin
        if (sw) check("R3 swapped", wr_out_data, 8'hFF);
        else    check("R4 passthru", wr_out_data, pv[n]);
        n++;
      end
      @(negedge clk);
    end
    wr_out_ready = 1'b0;
    check("R2 back to fill", {wr_out_valid, wr_in_ready}, 2'b01);
  endtask

  task automatic run_rd(input int gap_pct);
    logic dirty_exp;
    dirty_exp = 1'b0;
    for (int i = 0; i < NT; i++) begin
      while (($urandom % 100) < gap_pct) begin
        rd_valid = 1'b0;
        @(negedge clk);
        check("R6 no early done", rd_done, 0);
      end
      rd_valid = 1'b1;
      rd_data  = sec[i];
      if (sec[i] != 8'hFF) dirty_exp = 1'b1;
      @(negedge clk);
      rd_valid = 1'b0;
      if (i < NT - 1) begin
        check("R9 dirty", rd_dirty, dirty_exp);
        check("R6 done low", rd_done, 0);
      end
    end
    check("R6 done pulse", rd_done, 1);
    check("R7 erased", rd_erased, !dirty_exp);
    check("R8 decode_go", rd_decode_go, dirty_exp);
    check("R9 dirty cleared", rd_dirty, 0);
    @(negedge clk);
    check("R6 one cycle", {rd_done, rd_erased, rd_decode_go}, 3'b000);
  endtask

  task automatic fill_sec(input int dirty_pos, input int rnd_pct);
    for (int i = 0; i < NT; i++)
      sec[i] = (($urandom % 1000) < rnd_pct) ? 8'($urandom) : 8'hFF;
    if (dirty_pos >= 0) sec[dirty_pos] = 8'h7F;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    wr_in_valid = 1'b0; wr_in_data = '0; wr_out_ready = 1'b0;
    rd_valid = 1'b0; rd_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", {wr_in_ready, wr_out_valid, rd_done, rd_erased, rd_decode_go, rd_dirty},
          6'b100000);

    // Exact blank-sector parity.
    for (int i = 0; i < NP; i++) pv[i] = GOLD[i];
    run_wr(0);
    run_wr(50);
    // Single-byte near misses at first, middle, last.
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < NP; i++) pv[i] = GOLD[i];
      pv[k == 0 ? 0 : (k == 1 ? 4 : 8)] ^= 8'h01;
      run_wr(30);
    end
    // All 0xFF parity passes through unchanged.
    for (int i = 0; i < NP; i++) pv[i] = 8'hFF;
    run_wr(20);
    // Random parity.
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < NP; i++) pv[i] = 8'($urandom);
      run_wr(40);
    end

    // Read path: blank, then single dirty positions, then random.
    fill_sec(-1, 0);  run_rd(0);
    fill_sec(0, 0);   run_rd(10);
    fill_sec(9, 0);   run_rd(0);
    fill_sec(265, 0); run_rd(0);
    fill_sec(520, 0); run_rd(20);
    fill_sec(-1, 0);  run_rd(30);
    for (int t = 0; t < 3; t++) begin
      fill_sec(-1, 5); run_rd(10);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule